// File: doc/BRIEF.md
# Serial Register Port with Burst Access

This block is the host-facing end of a register bank: a synchronous serial slave with an active-low select, a serial clock, a data input and a data output with its own drive enable. The host opens a transfer by pulling select low and shifting in a command byte. The command chooses read or write and one of sixteen register addresses. Exactly one data byte follows, unless burst is requested at address zero. In burst mode the port walks the registers upward, one byte per eight clocks, until select rises.

Toward the core the port presents a plain register-file interface: an address, write data, a one-cycle write strobe, a one-cycle read strobe, and a read-data input that the core drives combinationally from the address. The serial pins are oversampled by the block clock through a short synchronizer, so all internal logic runs on one clock. After a single-register read of either status register completes, the port pulses a read-done flag and gives that register's address. The core can use this pulse to clear sticky status bits. A burst read never raises this flag.

Top module: `regport_serial`

## Requirements
- R1: While `cs_n` is high the port is idle. `sdo_oe` is low and no strobe fires. Raising `cs_n` part-way through a byte discards that byte, so no write takes place.
- R2: Every byte is shifted least significant bit first. In the command byte, bit 0 = 1 means read and bit 0 = 0 means write. Bits 4..1 form the address, with bit 4 as the MSB. Bits 6..5 are reserved. Bit 7 requests burst.
- R3: In a write, the eight rising `sck` edges after the command carry the data. The port then raises `reg_we` for exactly one cycle with `reg_addr` and `reg_wdata`.
- R4: In a read, the selected register is driven on `sdo` LSB first. `sdo` changes only on falling `sck` edges, and the first data bit appears on the first falling edge after the eighth command bit.
- R5: `sdo_oe` is high only during the data phase of a read. It is low during the command byte and throughout writes.
- R6: Burst mode is used only when bit 7 is set and the address is 0. Each further byte then goes to the next higher address. A command with bit 7 set and a nonzero address moves a single byte.
- R7: Addresses 11 to 15 read as 0x00 and ignore writes. A burst stops advancing at address 11, so bytes beyond the last register are discarded on write and read as zero.
- R8: A non-burst read of a status register (addresses 5 and 7) pulses `rd_done` for one cycle after the eighth data bit, with `rd_done_addr` set to that address. Burst reads and reads of any other address never pulse `rd_done`.
- R9: `reg_we` fires at most once per data byte, and only for addresses 0 to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low transfer select |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, sampled on rising `sck` |
| sdo | output | 1 | Serial data out, updated on falling `sck` |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means high impedance |
| reg_addr | output | 4 | Register address toward the core |
| reg_wdata | output | 8 | Write data toward the core |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe while `reg_rdata` is captured |
| reg_rdata | input | 8 | Read data from the core, combinational on `reg_addr` |
| rd_done | output | 1 | One-cycle pulse after a single status-register read |
| rd_done_addr | output | 4 | Address of the status register just read |

## Verification
Several properties are checked on every cycle:
- `sdo` changes only after a falling serial edge.
- Write strobes are single pulses aimed at implemented addresses.
- `rd_done` only ever names a status register.
- A deasserted select forces the command phase on the next cycle.
- The write strobe is never active while the output is enabled.

The bench scenarios show the rest. They cover bit ordering and field positions, correct read-back of every address, the upward burst walk and its stop at address 11, the single-byte behaviour of a burst bit at a nonzero address, the loss of a write aborted by select, and the absence of `rd_done` during burst reads.

// File: rtl/regport_pkg.sv
package regport_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    // Field order follows bit position of the command byte (bit 7 down to 0).
    typedef struct packed {
        logic              burst;
        logic [1:0]        rsvd;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] b);
        return cmd_t'(b);
    endfunction

    function automatic logic addr_ok(input logic [ADDR_W-1:0] a, input int unsigned last);
        return a <= ADDR_W'(last);
    endfunction

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic sdi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic sdi_s
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] sck_p, cs_p, di_p;
    logic              sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p    <= '1;
            cs_p     <= '1;
            di_p     <= '0;
            sck_last <= 1'b1;
        end else begin
            sck_p    <= {sck_p[STAGES-2:0], sck};
            cs_p     <= {cs_p[STAGES-2:0], cs_n};
            di_p     <= {di_p[STAGES-2:0], sdi};
            sck_last <= sck_p[TOP];
        end
    end

    assign sck_rise = sck_p[TOP] & ~sck_last;
    assign sck_fall = ~sck_p[TOP] & sck_last;
    assign cs_act   = ~cs_p[TOP];
    assign sdi_s    = di_p[TOP];

endmodule

// File: rtl/regport_rxshift.sv
module regport_rxshift
    import regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_val
);
    localparam int unsigned CW = $clog2(DATA_W);

    logic [DATA_W-2:0] shreg;
    logic [CW-1:0]     cnt;

    assign byte_done = shift_en && (cnt == CW'(DATA_W - 1));
    assign byte_val  = {bit_in, shreg};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (shift_en) begin
            shreg <= {bit_in, shreg[DATA_W-2:1]};
            cnt   <= byte_done ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/regport_txshift.sv
module regport_txshift
    import regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              sdo
);
    logic [DATA_W-1:0] tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx  <= '0;
            sdo <= 1'b0;
        end else if (load) begin
            tx <= load_data;
        end else if (shift) begin
            sdo <= tx[0];
            tx  <= {1'b0, tx[DATA_W-1:1]};
        end
    end

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(shift) |-> $stable(sdo)); // R4

endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
    import regport_pkg::*;
#(
    parameter int unsigned LAST_REG = 10,
    parameter int unsigned STAT_A   = 5,
    parameter int unsigned STAT_B   = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_val,
    output phase_e            phase,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] we_addr,
    output logic [ADDR_W-1:0] done_addr,
    output logic [DATA_W-1:0] wdata,
    output logic              fetch,
    output logic              we,
    output logic              done
);
    localparam logic [ADDR_W-1:0] STOP_ADDR = ADDR_W'(LAST_REG + 1);

    cmd_t cmd;
    logic burst;

    assign cmd = decode_cmd(byte_val);

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
        return (a < STOP_ADDR) ? a + 1'b1 : a;
    endfunction

    function automatic logic is_status(input logic [ADDR_W-1:0] a);
        return (a == ADDR_W'(STAT_A)) || (a == ADDR_W'(STAT_B));
    endfunction

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            phase     <= PH_CMD;
            cur_addr  <= '0;
            burst     <= 1'b0;
            fetch     <= 1'b0;
            we        <= 1'b0;
            done      <= 1'b0;
            we_addr   <= '0;
            wdata     <= '0;
            done_addr <= '0;
        end else begin
            fetch <= 1'b0;
            we    <= 1'b0;
            done  <= 1'b0;
            if (byte_done) begin
                unique case (phase)
                    PH_CMD: begin
                        cur_addr <= cmd.addr;
                        burst    <= cmd.burst && (cmd.addr == '0);
                        if (cmd.rd) begin
                            phase <= PH_RD;
                            fetch <= 1'b1;
                        end else begin
                            phase <= PH_WR;
                        end
                    end
                    PH_WR: begin
                        we      <= addr_ok(cur_addr, LAST_REG);
                        we_addr <= cur_addr;
                        wdata   <= byte_val;
                        if (burst) cur_addr <= next_addr(cur_addr);
                        else       phase    <= PH_HOLD;
                    end
                    PH_RD: begin
                        if (burst) begin
                            cur_addr <= next_addr(cur_addr);
                            fetch    <= 1'b1;
                        end else begin
                            phase     <= PH_HOLD;
                            done      <= is_status(cur_addr);
                            done_addr <= cur_addr;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        we |-> (we_addr <= ADDR_W'(LAST_REG))); // R9
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        we |=> !we); // R3
    AST_DONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        done |-> is_status(done_addr)); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (phase == PH_CMD) && !we && !fetch); // R1

endmodule

// File: rtl/regport_serial.sv
module regport_serial
    import regport_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LAST_REG    = 10,
    parameter int unsigned STAT_A      = 5,
    parameter int unsigned STAT_B      = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              rd_done,
    output logic [ADDR_W-1:0] rd_done_addr
);
    logic              sck_rise, sck_fall, cs_act, sdi_s;
    logic              byte_done, fetch, addr_valid;
    logic [DATA_W-1:0] byte_val, load_data;
    logic [ADDR_W-1:0] cur_addr, we_addr;
    phase_e            phase;

    regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdi(sdi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .sdi_s(sdi_s)
    );

    regport_rxshift u_rx (
        .clk(clk), .rst(rst), .clr(!cs_act), .shift_en(sck_rise && cs_act),
        .bit_in(sdi_s), .byte_done(byte_done), .byte_val(byte_val)
    );

    regport_ctrl #(.LAST_REG(LAST_REG), .STAT_A(STAT_A), .STAT_B(STAT_B)) u_ctrl (
        .clk(clk), .rst(rst), .cs_act(cs_act), .byte_done(byte_done),
        .byte_val(byte_val), .phase(phase), .cur_addr(cur_addr), .we_addr(we_addr),
        .done_addr(rd_done_addr), .wdata(reg_wdata), .fetch(fetch), .we(reg_we),
        .done(rd_done)
    );

    assign addr_valid = addr_ok(cur_addr, LAST_REG);
    assign load_data  = addr_valid ? reg_rdata : '0;
    assign reg_re     = fetch && addr_valid;
    assign reg_addr   = reg_we ? we_addr : cur_addr;
    assign sdo_oe     = cs_act && (phase == PH_RD);

    regport_txshift u_tx (
        .clk(clk), .rst(rst), .load(fetch), .load_data(load_data),
        .shift(sck_fall && sdo_oe), .sdo(sdo)
    );

    AST_OE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> !reg_we); // R5
    AST_RE_NO_WE: assert property (@(posedge clk) disable iff (rst)
        !(reg_re && reg_we)); // R9

endmodule

// File: tb/test_regport_serial.sv
`timescale 1ns/1ps
module test_regport_serial;
    localparam time HALF = 80ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sck = 1'b1, sdi = 1'b0;
    logic       sdo, sdo_oe, reg_we, reg_re, rd_done;
    logic [3:0] reg_addr, rd_done_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] mem [0:10];
    int         checks = 0, failures = 0;
    int         we_cnt = 0, bad_we = 0, done_cnt = 0;
    logic [3:0] last_done;
    logic       in_write = 1'b0, oe_in_write = 1'b0, finished = 1'b0;

    always #5 clk = ~clk;

    regport_serial i_regport_serial (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .rd_done(rd_done), .rd_done_addr(rd_done_addr)
    );

    assign reg_rdata = (reg_addr <= 4'd10) ? mem[reg_addr] : 8'hEE;

    always @(posedge clk) begin
        if (!rst) begin
            if (reg_we) begin
                we_cnt <= we_cnt + 1;
                if (reg_addr > 4'd10) bad_we <= bad_we + 1;
                else mem[reg_addr] <= reg_wdata;
            end
            if (rd_done) begin
                done_cnt  <= done_cnt + 1;
                last_done <= rd_done_addr;
            end
            if (in_write && sdo_oe) oe_in_write <= 1'b1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
        oe_all = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sck = 1'b0; sdi = tx[i];
            #(HALF);
            rx[i] = sdo; oe_all &= sdo_oe;
            sck = 1'b1;
            #(HALF);
        end
    endtask

    task automatic open_cs;  cs_n = 1'b0; #(HALF); endtask
    task automatic close_cs; sck = 1'b1; cs_n = 1'b1; #(4*HALF); endtask

    function automatic logic [7:0] cmdb(input logic rd, input logic [3:0] a, input logic b);
        return {b, 2'b00, a, rd};
    endfunction

    task automatic wr1(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] rx; logic oe;
        in_write = 1'b1;
        open_cs; xbyte(cmdb(1'b0, a, 1'b0), rx, oe); xbyte(d, rx, oe); close_cs;
        in_write = 1'b0;
    endtask

    task automatic rd1(input logic [3:0] a, output logic [7:0] v, output logic oe);
        logic [7:0] rx; logic oe0;
        open_cs; xbyte(cmdb(1'b1, a, 1'b0), rx, oe0); xbyte(8'h00, v, oe); close_cs;
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    initial begin
        logic [7:0] v, rx;
        logic oe;
        int w0, d0;
        for (int i = 0; i <= 10; i++) mem[i] = 8'h00;
        repeat (5) @(posedge clk);
        #3 rst = 1'b0;
        #(2*HALF);
        // R1: reset / idle state
        chk(sdo_oe == 1'b0 && reg_we == 1'b0 && rd_done == 1'b0, "R1 idle", int'(sdo_oe), 0);

        // R2 R3 R4 R7 R8 R9: every address, single write then single read
        for (int a = 0; a < 16; a++) begin
            w0 = we_cnt; d0 = done_cnt;
            wr1(4'(a), pat(a));
            chk(we_cnt - w0 == ((a <= 10) ? 1 : 0), "R9 we count", we_cnt - w0, (a <= 10) ? 1 : 0);
            rd1(4'(a), v, oe);
            chk(v == ((a <= 10) ? pat(a) : 8'h00), "R4/R7 read back", v, (a <= 10) ? pat(a) : 0);
            chk(oe == 1'b1, "R5 oe in read", oe, 1);
            chk(done_cnt - d0 == ((a == 5 || a == 7) ? 1 : 0), "R8 done count", done_cnt - d0,
                (a == 5 || a == 7) ? 1 : 0);
            if (a == 5 || a == 7) chk(last_done == 4'(a), "R8 done addr", last_done, a);
        end
        chk(oe_in_write == 1'b0, "R5 oe low in writes", oe_in_write, 0);
        chk(bad_we == 0, "R7 no write above last", bad_we, 0);

        // R6 R7: burst write of 13 bytes from address 0
        w0 = we_cnt;
        in_write = 1'b1;
        open_cs; xbyte(cmdb(1'b0, 4'd0, 1'b1), rx, oe);
        for (int i = 0; i < 13; i++) xbyte(8'hA0 ^ 8'(i * 3), rx, oe);
        close_cs;
        in_write = 1'b0;
        chk(we_cnt - w0 == 11, "R7 burst write stops", we_cnt - w0, 11);
        chk(oe_in_write == 1'b0, "R5 oe low in burst write", oe_in_write, 0);

        // R6 R8: burst read of 13 bytes
        d0 = done_cnt;
        open_cs; xbyte(cmdb(1'b1, 4'd0, 1'b1), rx, oe);
        for (int i = 0; i < 13; i++) begin
            xbyte(8'h00, v, oe);
            chk(v == ((i <= 10) ? (8'hA0 ^ 8'(i * 3)) : 8'h00), "R6 burst read",
                v, (i <= 10) ? (8'hA0 ^ (i * 3)) : 0);
        end
        close_cs;
        chk(done_cnt == d0, "R8 no done in burst", done_cnt - d0, 0);

        // R6: burst bit with nonzero address moves one byte only
        in_write = 1'b1;
        open_cs; xbyte(cmdb(1'b0, 4'd3, 1'b1), rx, oe);
        xbyte(8'h11, rx, oe); xbyte(8'h22, rx, oe); close_cs;
        in_write = 1'b0;
        rd1(4'd3, v, oe); chk(v == 8'h11, "R6 single at addr3", v, 8'h11);
        rd1(4'd4, v, oe); chk(v == (8'hA0 ^ 8'd12), "R6 addr4 untouched", v, 8'hA0 ^ 12);

        // R1: abort in the middle of a data byte
        w0 = we_cnt;
        open_cs; xbyte(cmdb(1'b0, 4'd2, 1'b0), rx, oe);
        for (int i = 0; i < 4; i++) begin
            sck = 1'b0; sdi = 1'b1; #(HALF); sck = 1'b1; #(HALF);
        end
        close_cs;
        chk(we_cnt == w0, "R1 abort no write", we_cnt - w0, 0);
        chk(sdo_oe == 1'b0, "R1 oe low after cs", sdo_oe, 0);
        rd1(4'd2, v, oe); chk(v == (8'hA0 ^ 8'd6), "R1 addr2 kept", v, 8'hA0 ^ 6);

        // R2: bit 0 = 1 reads with no write strobe
        w0 = we_cnt;
        rd1(4'd9, v, oe);
        chk(we_cnt == w0 && v == (8'hA0 ^ 8'd27), "R2 read no write", v, 8'hA0 ^ 27);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1ms;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule